// File: doc/BRIEF.md
# Linked-Line Text Display Fetcher

This block is the screen-memory walker of a character-cell video controller. Screen memory is two parallel 4 KB banks read at the same address: a character bank and an attribute bank. The display is not a fixed raster. Each displayed line is a run of character bytes that ends with the terminator byte FFh. The two character bytes after the terminator give the 12-bit start address of the next line. The attribute byte that sits beside the pointer's low byte holds the line attributes of the line it points to. On every vertical reset the walker starts again at address 0. It emits the line once for each scan row that the line shows, and for each character it delivers the code, decoded character attributes, the line attributes, the scan row and the character-generator address.

A small write-only command register sits beside the walker. It holds a 4-bit smooth-scroll latch, a blink flip-flop, a reverse-field flag and a vertical-interrupt request. The latch is copied into the walker at vertical reset, so a new value acts one frame later. Characters leave on a valid/ready stream. An item stays on the outputs, unchanged, until the sink takes it with ready high at a clock edge. A vertical reset flushes the walker and drops a pending item. Memory reads have a fixed latency of one cycle and are always served. Arbitration with a CPU happens outside this block.

Top module: `lined_fetch`

## Requirements
- R1: In the cycle after vreset is sampled high, the block issues a read of address 0. The first line has its scroll flag cleared and size code 11, and it starts at scan row 0.
- R2: Character byte FFh ends a line. The next byte gives the pointer low byte, and the byte after it gives the high nibble (bits 3:0) of the 12-bit address of the next line. Bits 2:0 of the attribute byte read with the low byte become the next line's attributes: bit 0 is the scroll flag and bits 2:1 are the size code (00 lower half of tall, 01 upper half of tall, 10 wide, 11 normal). They appear on out_scroll and out_size.
- R3: out_attr is {underline, blink, bold, reverse}, all active high. Bits 3, 2 and 1 of the attribute byte are inverted, bit 0 is passed through unchanged, and bits 7:4 are ignored.
- R4: A line is emitted once per displayed scan row, in ascending row order. Rows are numbered 0 to 9, and out_row gives the row.
- R5: Let N be the working scroll value. A line whose scroll flag is set, following a line whose flag is clear, starts at row N. A line with its flag set whose next line has the flag clear ends at row N-1 when N is not 0. Every line ends at row 9 at the latest.
- R6: Command codes 0 to 3 write bits 1:0 of the scroll latch and codes 4 to 7 write bits 3:2, taking the value from bits 1:0 of the code. The latch becomes the working value only at vertical reset (a latch above 9 acts as 0), so a write during a frame does not change that frame.
- R7: Code 8 toggles blink_state. Code A sets reverse_field and code B clears it. Codes C to F change nothing.
- R8: vint_req goes high in the cycle after a vertical reset and stays high until code 9 is written. A vertical reset in the same cycle as code 9 leaves it high.
- R9: out_cg_addr is code*16 + s, where s is F for row 0 and row-1 for rows 1 to 9.
- R10: After 256 characters without a terminator, the next byte is taken as the pointer low byte, as if a terminator had been read.
- R11: While out_valid is high and out_ready is low, every stream output holds its value.
- R12: After reset, out_valid, mem_rd, blink_state, reverse_field and vint_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vreset | input | 1 | Vertical reset pulse; restarts the frame |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 4 | Command code |
| mem_rd | output | 1 | Screen memory read request |
| mem_addr | output | 12 | Screen memory read address |
| mem_char | input | 8 | Character byte, one cycle after mem_rd |
| mem_attr | input | 8 | Attribute byte, one cycle after mem_rd |
| out_valid | output | 1 | Stream item present |
| out_ready | input | 1 | Sink accepts the item |
| out_code | output | 8 | Character code |
| out_attr | output | 4 | {underline, blink, bold, reverse}, active high |
| out_scroll | output | 1 | Line scroll-region flag |
| out_size | output | 2 | Line size code |
| out_row | output | 4 | Scan row 0 to 9 |
| out_cg_addr | output | 12 | Character generator address |
| blink_state | output | 1 | Blink flip-flop |
| reverse_field | output | 1 | Whole-screen reverse flag |
| vint_req | output | 1 | Vertical interrupt request |

## Verification
The bench runs a four-line linked screen with scroll value 0 and then with value 5. The first run shows that scroll flags alone do not clip rows. The second shows the start row of the first region line, the end row of the last region line, and the full rows of the lines around them. A latch write in the middle of a frame separates deferred from immediate use. A screen with no terminator for over 256 bytes separates the runaway cut from a plain wrap through memory. An irregular ready pattern tests holding under stalls. Pointers with a high nibble that is not zero and varied attribute nibbles catch swapped pointer bytes and wrong polarity.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int LF_ADDR_W = 12;
  localparam int LF_ROWS   = 10;
  localparam int LF_ROW_W  = 4;
  localparam logic [7:0] LF_TERM = 8'hFF;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_OUT} lf_state_e;
  typedef enum logic [1:0] {PH_CHAR, PH_PLO, PH_PHI} lf_phase_e;

  typedef struct packed {
    logic [1:0] size;
    logic       scroll;
  } lf_lattr_t;
endpackage

// File: rtl/lf_cmd_reg.sv
module lf_cmd_reg
  import lf_pkg::*;
#(
  parameter int LATCH_W = LF_ROW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vreset,
  input  logic               cmd_we,
  input  logic [3:0]         cmd_code,
  output logic [LATCH_W-1:0] scroll_latch,
  output logic               blink,
  output logic               rev,
  output logic               vint
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scroll_latch <= '0;
      blink        <= 1'b0;
      rev          <= 1'b0;
      vint         <= 1'b0;
    end else begin
      if (cmd_we) begin
        unique case (cmd_code[3:2])
          2'b00: scroll_latch[1:0] <= cmd_code[1:0];
          2'b01: scroll_latch[3:2] <= cmd_code[1:0];
          2'b10: begin
            unique case (cmd_code[1:0])
              2'b00: blink <= ~blink;
              2'b01: vint  <= 1'b0;
              2'b10: rev   <= 1'b1;
              2'b11: rev   <= 1'b0;
            endcase
          end
          2'b11: ;
        endcase
      end
      if (vreset) vint <= 1'b1;
    end
  end

  assert_vint_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vreset |=> vint);
  assert_vint_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code == 4'h9 && !vreset) |=> !vint);
  assert_blink_tgl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code == 4'h8) |=> (blink != $past(blink)));
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(scroll_latch));
endmodule

// File: rtl/lf_cg_addr.sv
module lf_cg_addr
  import lf_pkg::*;
(
  input  logic [7:0]          code,
  input  logic [LF_ROW_W-1:0] row,
  output logic [11:0]         cg_addr
);
  logic [3:0] scan_nib;
  always_comb begin
    if (row == '0) scan_nib = 4'hF;
    else           scan_nib = 4'(row - LF_ROW_W'(1));
    cg_addr = {code, scan_nib};
  end
endmodule

// File: rtl/lf_walker.sv
module lf_walker
  import lf_pkg::*;
#(
  parameter int AW        = LF_ADDR_W,
  parameter int ROWS      = LF_ROWS,
  parameter int RW        = LF_ROW_W,
  parameter int MAX_CHARS = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vreset,
  input  logic [RW-1:0] scroll_latch,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_char,
  input  logic [7:0]    mem_attr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_code,
  output logic [3:0]    out_attr,
  output logic          out_scroll,
  output logic [1:0]    out_size,
  output logic [RW-1:0] out_row
);
  localparam int CW = $clog2(MAX_CHARS + 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  lf_state_e     state;
  lf_phase_e     ph;
  logic [AW-1:0] addr, line_addr;
  logic [7:0]    ptr_lo, code_q;
  logic [3:0]    attr_q;
  lf_lattr_t     cur, nxt;
  logic [RW-1:0] row, scr_n, end_row, start_row;
  logic [CW-1:0] cnt;
  logic [AW-1:0] ptr;
  logic          last_pass;
  logic          unused_attr_hi;

  assign unused_attr_hi = ^mem_attr[7:4];
  assign ptr       = AW'({mem_char, ptr_lo});
  assign end_row   = (scr_n == '0) ? LAST_ROW : scr_n - RW'(1);
  assign last_pass = (row == LAST_ROW) || (cur.scroll && !nxt.scroll && row == end_row);
  assign start_row = (nxt.scroll && !cur.scroll) ? scr_n : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; ph <= PH_CHAR;
      addr <= '0; line_addr <= '0; ptr_lo <= '0; code_q <= '0; attr_q <= '0;
      cur <= '{size: 2'b11, scroll: 1'b0}; nxt <= '0;
      row <= '0; scr_n <= '0; cnt <= '0;
    end else if (vreset) begin
      state <= ST_REQ; ph <= PH_CHAR;
      addr <= '0; line_addr <= '0; cnt <= '0; row <= '0;
      cur <= '{size: 2'b11, scroll: 1'b0};
      scr_n <= (scroll_latch > LAST_ROW) ? '0 : scroll_latch;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_REQ:  state <= ST_WAIT;
        ST_WAIT: begin
          unique case (ph)
            PH_CHAR: begin
              if (mem_char == LF_TERM) begin
                ph <= PH_PLO; addr <= addr + AW'(1); state <= ST_REQ;
              end else begin
                code_q <= mem_char; attr_q <= mem_attr[3:0]; state <= ST_OUT;
              end
            end
            PH_PLO: begin
              ptr_lo <= mem_char; nxt <= lf_lattr_t'(mem_attr[2:0]);
              addr <= addr + AW'(1); ph <= PH_PHI; state <= ST_REQ;
            end
            default: begin
              ph <= PH_CHAR; cnt <= '0; state <= ST_REQ;
              if (last_pass) begin
                line_addr <= ptr; addr <= ptr; cur <= nxt; row <= start_row;
              end else begin
                addr <= line_addr; row <= row + RW'(1);
              end
            end
          endcase
        end
        ST_OUT: begin
          if (out_ready) begin
            addr  <= addr + AW'(1);
            cnt   <= cnt + CW'(1);
            ph    <= (cnt == CW'(MAX_CHARS - 1)) ? PH_PLO : PH_CHAR;
            state <= ST_REQ;
          end
        end
      endcase
    end
  end

  assign mem_rd     = (state == ST_REQ);
  assign mem_addr   = addr;
  assign out_valid  = (state == ST_OUT);
  assign out_code   = code_q;
  assign out_attr   = {~attr_q[3], ~attr_q[2], ~attr_q[1], attr_q[0]};
  assign out_scroll = cur.scroll;
  assign out_size   = cur.size;
  assign out_row    = row;

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !vreset) |=>
      (out_valid && $stable(out_code) && $stable(out_attr) && $stable(out_row)
       && $stable(out_scroll) && $stable(out_size)));
  assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vreset |=> (mem_rd && mem_addr == '0 && out_row == '0 && !out_scroll));
  assert_row_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_row <= LAST_ROW);
  assert_char_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_CHARS));
endmodule

// File: rtl/lined_fetch.sv
module lined_fetch
  import lf_pkg::*;
#(
  parameter int AW        = LF_ADDR_W,
  parameter int MAX_CHARS = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vreset,
  input  logic          cmd_we,
  input  logic [3:0]    cmd_code,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_char,
  input  logic [7:0]    mem_attr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_code,
  output logic [3:0]    out_attr,
  output logic          out_scroll,
  output logic [1:0]    out_size,
  output logic [3:0]    out_row,
  output logic [11:0]   out_cg_addr,
  output logic          blink_state,
  output logic          reverse_field,
  output logic          vint_req
);
  logic [LF_ROW_W-1:0] latch;

  lf_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .vreset(vreset), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .scroll_latch(latch), .blink(blink_state), .rev(reverse_field), .vint(vint_req)
  );

  lf_walker #(.AW(AW), .ROWS(LF_ROWS), .RW(LF_ROW_W), .MAX_CHARS(MAX_CHARS)) u_walk (
    .clk(clk), .rst_n(rst_n), .vreset(vreset), .scroll_latch(latch),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_char(mem_char), .mem_attr(mem_attr),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
    .out_attr(out_attr), .out_scroll(out_scroll), .out_size(out_size), .out_row(out_row)
  );

  lf_cg_addr u_cg (.code(out_code), .row(out_row), .cg_addr(out_cg_addr));
endmodule

// File: tb/lined_fetch_tb.sv
module lined_fetch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vreset = 1'b0, cmd_we = 1'b0, out_ready = 1'b0;
  logic [3:0] cmd_code = 4'h0;
  logic mem_rd, out_valid, out_scroll, blink_state, reverse_field, vint_req;
  logic [11:0] mem_addr, out_cg_addr;
  logic [7:0] mem_char, mem_attr, out_code;
  logic [3:0] out_attr, out_row;
  logic [1:0] out_size;

  logic [7:0] scr_c [0:4095];
  logic [7:0] scr_a [0:4095];

  int checks = 0, errors = 0, cycles = 0, idx = 0, n_exp = 0, tick = 0;
  int exp_pack [0:2999];

  always #10 clk = ~clk;

  lined_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .vreset(vreset), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_char(mem_char), .mem_attr(mem_attr),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code), .out_attr(out_attr),
    .out_scroll(out_scroll), .out_size(out_size), .out_row(out_row),
    .out_cg_addr(out_cg_addr), .blink_state(blink_state), .reverse_field(reverse_field),
    .vint_req(vint_req)
  );

  always_ff @(posedge clk) if (mem_rd) begin
    mem_char <= scr_c[mem_addr];
    mem_attr <= scr_a[mem_addr];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1; checks = checks + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic int pack(input logic [7:0] c, input logic [3:0] a, input logic [3:0] r,
                              input logic [2:0] la, input logic [11:0] cg);
    return int'({1'b0, c, a, r, la, cg});
  endfunction

  // Expected stream computed from R2..R5, R9, R10
  task automatic build_expect(input int nsc, input int limit);
    int la, row, a, cnt, st, er, ptr;
    logic [2:0] cur, nl;
    logic [7:0] lo, c, at;
    logic [3:0] sn;
    n_exp = 0; la = 0; cur = 3'b110; row = 0;
    er = (nsc == 0) ? 9 : nsc - 1;
    while (n_exp < limit) begin
      a = la; cnt = 0;
      while (scr_c[a] != 8'hFF && cnt < 256 && n_exp < limit) begin
        c = scr_c[a]; at = scr_a[a];
        sn = (row == 0) ? 4'hF : 4'(row - 1);
        exp_pack[n_exp] = pack(c, {~at[3], ~at[2], ~at[1], at[0]}, 4'(row), cur,
                               12'(int'(c) * 16 + int'(sn)));
        n_exp++; a = (a + 1) % 4096; cnt++;
      end
      if (n_exp >= limit) break;
      if (cnt < 256) a = (a + 1) % 4096;
      lo = scr_c[a]; nl = scr_a[a][2:0]; a = (a + 1) % 4096;
      ptr = int'({scr_c[a][3:0], lo});
      if (row == 9 || (cur[0] && !nl[0] && row == er)) begin
        st = (nl[0] && !cur[0]) ? nsc : 0;
        cur = nl; la = ptr; row = st;
      end else row++;
    end
  endtask

  task automatic collect(input int upto, input bit bp, input string tag);
    bit pv = 0;
    int pk = 0;
    while (idx < upto) begin
      @(negedge clk);
      tick++;
      out_ready = bp ? ((tick % 3) != 0) : 1'b1;
      #1;
      if (pv) chk(out_valid && pack(out_code, out_attr, out_row, {out_size, out_scroll},
                  out_cg_addr) == pk, "R11 hold under stall",
                  pack(out_code, out_attr, out_row, {out_size, out_scroll}, out_cg_addr), pk);
      pv = out_valid && !out_ready;
      pk = pack(out_code, out_attr, out_row, {out_size, out_scroll}, out_cg_addr);
      if (out_valid && out_ready) begin
        chk(pk == exp_pack[idx], tag, pk, exp_pack[idx]);
        idx++;
      end
    end
  endtask

  task automatic frame_start();
    @(negedge clk);
    out_ready = 1'b0; vreset = 1'b1;
    @(negedge clk);
    vreset = 1'b0;
    chk(mem_rd && mem_addr == 12'h000, "R1 restart read at 0", int'(mem_addr), 0);
    idx = 0;
  endtask

  task automatic send_cmd(input logic [3:0] c);
    @(negedge clk);
    out_ready = 1'b0; cmd_we = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) begin scr_c[i] = 8'h00; scr_a[i] = 8'h00; end
  endtask

  task automatic put(input int a, input logic [7:0] c, input logic [7:0] at);
    scr_c[a] = c; scr_a[a] = at;
  endtask

  initial begin
    logic b0, r0, v0;
    clear_mem();
    // four linked lines; pointer to 0x730 has non-zero high nibble
    put(12'h000, 8'h41, 8'hFE); put(12'h001, 8'h42, 8'hF1); put(12'h002, 8'hFF, 8'h00);
    put(12'h003, 8'h10, 8'h01); put(12'h004, 8'h00, 8'h00);
    put(12'h010, 8'h43, 8'h05); put(12'h011, 8'hFF, 8'h00);
    put(12'h012, 8'h20, 8'h03); put(12'h013, 8'h00, 8'h00);
    put(12'h020, 8'h44, 8'h0A); put(12'h021, 8'h45, 8'h00); put(12'h022, 8'hFF, 8'h00);
    put(12'h023, 8'h30, 8'h04); put(12'h024, 8'h07, 8'h00);
    put(12'h730, 8'hFE, 8'h08); put(12'h731, 8'hFF, 8'h00);
    put(12'h732, 8'h00, 8'h06); put(12'h733, 8'h00, 8'h00);

    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!out_valid && !mem_rd, "R12 reset stream idle", int'({out_valid, mem_rd}), 0);
    chk(!blink_state && !reverse_field && !vint_req, "R12 reset flags",
        int'({blink_state, reverse_field, vint_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Frame with scroll 0: R2 R3 R4 R9; latch write mid-frame must not apply (R6)
    build_expect(0, 120);
    frame_start();
    chk(vint_req, "R8 set by vertical reset", int'(vint_req), 1);
    collect(60, 1'b0, "R2 R3 R4 R9 R5 item, scroll 0");
    send_cmd(4'h1); send_cmd(4'h5);
    collect(120, 1'b0, "R6 deferred latch item");

    send_cmd(4'h9);
    chk(!vint_req, "R8 cleared by code 9", int'(vint_req), 0);
    @(negedge clk);
    cmd_we = 1'b1; cmd_code = 4'h9; vreset = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0; vreset = 1'b0;
    chk(vint_req, "R8 vreset wins over clear", int'(vint_req), 1);

    // R7 commands
    b0 = blink_state;
    send_cmd(4'h8);
    chk(blink_state == !b0, "R7 blink toggle", int'(blink_state), int'(!b0));
    send_cmd(4'h8);
    chk(blink_state == b0, "R7 blink toggle back", int'(blink_state), int'(b0));
    send_cmd(4'hA);
    chk(reverse_field, "R7 reverse on", int'(reverse_field), 1);
    send_cmd(4'hB);
    chk(!reverse_field, "R7 reverse off", int'(reverse_field), 0);
    send_cmd(4'hA);
    b0 = blink_state; r0 = reverse_field; v0 = vint_req;
    for (int c = 12; c < 16; c++) send_cmd(4'(c));
    chk({blink_state, reverse_field, vint_req} == {b0, r0, v0}, "R7 codes C-F ignored",
        int'({blink_state, reverse_field, vint_req}), int'({b0, r0, v0}));

    // Frame with scroll 5 (latch still 5 after C-F) and back-pressure: R5 R11
    build_expect(5, 150);
    frame_start();
    collect(150, 1'b1, "R5 scroll region rows, scroll 5");

    // Runaway line: no terminator for more than 256 bytes (R10)
    clear_mem();
    for (int i = 0; i < 300; i++) put(i, 8'(8'h20 + (i % 90)), 8'(i % 16));
    put(256, 8'h00, 8'h00); put(257, 8'h04, 8'h00);
    put(12'h400, 8'h5A, 8'h01); put(12'h401, 8'hFF, 8'h00);
    put(12'h402, 8'h00, 8'h06); put(12'h403, 8'h00, 8'h00);
    build_expect(5, 2600);
    frame_start();
    collect(2600, 1'b0, "R10 runaway cut item");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule